// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Interface

This block is the digital front end of a two-channel voltage DAC. A host writes 16-bit frames over a three-wire serial link made of a select line, a serial clock and a data line. While select is low, each rising serial clock edge shifts one bit into a 16-bit register, most significant bit first. When select returns high, the word is copied into a holding latch. Its top four bits are then decoded as a command that acts on a double-buffered latch pair in each channel. Each pair is an input latch followed by a DAC latch. A command can load the input latch only. It can copy the stored input latch into the DAC latch. It can also load and update in one step. Each of these acts on channel A, channel B, or both channels.

The two DAC-latch codes leave the block as parallel buses for the converter cores. The end of the shift register drives a serial output, so several devices can be chained. During a frame, this output carries the previous word. It changes on falling serial clock edges. The serial pins are oversampled by the block clock through two-flop synchronisers. Their edges are detected in that clock domain. A parameter selects a 12, 10 or 8-bit resolution. The code always takes the upper bits of the 12-bit data field.

Top module: `dual_dac_serial_if`

## Requirements
- R1: While `rst_n` or `clear_n` is low at a clock edge, every latch and the shift register are zero. Both codes then read 0, and the next frame shifts out 16 zero bits. `clear_n` overrides any command.
- R2: A frame is 16 bits, most significant bit first. Bits 15:12 are the command and bits 11:0 are the data. The word is captured when `sel_n` rises after the 16th clock.
- R3: Command 4'b0000 loads input latch A, and 4'b0011 loads input latch B. Neither changes any DAC code.
- R4: Command 4'b0001 copies input latch A into code A, and 4'b0100 copies input latch B into code B. The data field of these commands is ignored.
- R5: Command 4'b0010 loads input latch A and sets code A to the new data. Command 4'b0101 does the same for channel B.
- R6: Commands 4'b1100, 4'b1101 and 4'b1110 perform load, update and load-and-update on both channels at once.
- R7: Commands 4'b0110 through 4'b1011, and 4'b1111, change no input latch and no DAC latch.
- R8: Serial clock edges while `sel_n` is high do not shift the register.
- R9: During a frame, `sdout` presents the previous 16-bit word most significant bit first. It changes after falling `sclk` edges, so the value valid at the k-th rising edge is bit 16-k of that word.
- R10: With RES_BITS below 12, the code equals data bits 11 down to 12-RES_BITS. The lower data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| clear_n | input | 1 | Synchronous active-low clear of all latches |
| sel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out for chaining |
| code_a | output | RES_BITS | DAC latch A code |
| code_b | output | RES_BITS | DAC latch B code |

## Verification
The hardest state to reach from the ports is an input latch whose value differs from its DAC latch. It is invisible until a later update command exposes it. The stimulus loads different values with load-only commands and sends every no-op code with fresh data. It then issues an update, so any disturbance of a hidden latch shows up on the codes. Shift-register contents are reached the same way. Clocks are sent while select is high, and a clear is applied. The next frame then reveals the register through the serial output.

// File: rtl/dacif_pkg.sv
// Shared frame layout, command codes and per-channel control type.
// Assumes a fixed 16-bit frame of 4 command bits over 12 data bits.
package dacif_pkg;
    localparam int FRAME_W = 16;
    localparam int CMD_W   = 4;
    localparam int DATA_W  = FRAME_W - CMD_W;
    localparam int NCH     = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_LOAD_A   = 4'b0000,
        CMD_UPD_A    = 4'b0001,
        CMD_LDUP_A   = 4'b0010,
        CMD_LOAD_B   = 4'b0011,
        CMD_UPD_B    = 4'b0100,
        CMD_LDUP_B   = 4'b0101,
        CMD_LOAD_ALL = 4'b1100,
        CMD_UPD_ALL  = 4'b1101,
        CMD_LDUP_ALL = 4'b1110
    } cmd_e;

    typedef struct packed {
        logic load;
        logic upd;
    } chan_ctl_t;

    typedef chan_ctl_t [NCH-1:0] ctl_vec_t;

    // Map a command to load/update strobes; unknown codes give none.
    function automatic ctl_vec_t decode_cmd(input logic [CMD_W-1:0] c);
        ctl_vec_t v;
        v = '0;
        case (c)
            CMD_LOAD_A:   v[0].load = 1'b1;
            CMD_UPD_A:    v[0].upd  = 1'b1;
            CMD_LDUP_A:   begin v[0].load = 1'b1; v[0].upd = 1'b1; end
            CMD_LOAD_B:   v[1].load = 1'b1;
            CMD_UPD_B:    v[1].upd  = 1'b1;
            CMD_LDUP_B:   begin v[1].load = 1'b1; v[1].upd = 1'b1; end
            CMD_LOAD_ALL: begin v[0].load = 1'b1; v[1].load = 1'b1; end
            CMD_UPD_ALL:  begin v[0].upd  = 1'b1; v[1].upd  = 1'b1; end
            CMD_LDUP_ALL: v = '{default: '{load: 1'b1, upd: 1'b1}};
            default:      v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/dacif_serial_rx.sv
// Serial receiver: synchronises the three serial pins to clk, shifts on
// rising sclk while select is low, drives sdout from the register end on
// falling sclk (and while idle), and flags the rising edge of select.
// Assumes each sclk phase lasts at least three clk periods.
module dacif_serial_rx
    import dacif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_n,
    input  logic               sel_n,
    input  logic               sclk,
    input  logic               sdin,
    output logic               sdout,
    output logic               frame_end,
    output logic [FRAME_W-1:0] shift_q
);
    logic [SYNC_STAGES-1:0] sclk_sy, sel_sy, din_sy;
    logic sclk_d, sel_d;
    logic sclk_s, sel_s, din_s;
    logic sclk_rise, sclk_fall;

    assign sclk_s = sclk_sy[SYNC_STAGES-1];
    assign sel_s  = sel_sy[SYNC_STAGES-1];
    assign din_s  = din_sy[SYNC_STAGES-1];

    // Purpose: bring the asynchronous serial pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sy <= '0;
            sel_sy  <= '1;
            din_sy  <= '0;
            sclk_d  <= 1'b0;
            sel_d   <= 1'b1;
        end else begin
            sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
            sel_sy  <= {sel_sy[SYNC_STAGES-2:0], sel_n};
            din_sy  <= {din_sy[SYNC_STAGES-2:0], sdin};
            sclk_d  <= sclk_s;
            sel_d   <= sel_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d & ~sel_s;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign frame_end = sel_s & ~sel_d;

    // Purpose: shift register, MSB first, gated by the select line.
    always_ff @(posedge clk) begin
        if (!rst_n || !clear_n) begin
            shift_q <= '0;
        end else if (sclk_rise) begin
            shift_q <= {shift_q[FRAME_W-2:0], din_s};
        end
    end

    // Purpose: present the register end on falling sclk or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !clear_n) begin
            sdout <= 1'b0;
        end else if (sclk_fall || sel_s) begin
            sdout <= shift_q[FRAME_W-1];
        end
    end

    // R8
    idle_shift_hold_chk: assert property (@(posedge clk)
        disable iff (!rst_n || !clear_n) sel_s |=> $stable(shift_q));
endmodule

// File: rtl/dacif_cmd_decode.sv
// Holding latch and command decoder: copies the shift register when a
// frame ends, then one cycle later issues per-channel strobes.
// Assumes frame_end is a single-cycle pulse.
module dacif_cmd_decode
    import dacif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_n,
    input  logic               frame_end,
    input  logic [FRAME_W-1:0] shift_q,
    output ctl_vec_t           ctl,
    output logic [DATA_W-1:0]  data
);
    logic [FRAME_W-1:0] hold_q;
    logic               go_q;
    logic [CMD_W-1:0]   cmd;

    // Purpose: capture the finished word and arm the decode.
    always_ff @(posedge clk) begin
        if (!rst_n || !clear_n) begin
            hold_q <= '0;
            go_q   <= 1'b0;
        end else begin
            go_q <= frame_end;
            if (frame_end) hold_q <= shift_q;
        end
    end

    assign cmd  = hold_q[FRAME_W-1 -: CMD_W];
    assign data = hold_q[DATA_W-1:0];

    // Purpose: turn the held command into per-channel strobes.
    always_comb begin
        ctl = go_q ? decode_cmd(cmd) : '0;
    end

    // R7
    noop_no_strobe_chk: assert property (@(posedge clk)
        disable iff (!rst_n)
        (go_q && (cmd inside {[4'b0110:4'b1011], 4'b1111})) |-> (ctl == '0));
    // R6
    all_both_chan_chk: assert property (@(posedge clk)
        disable iff (!rst_n)
        (go_q && cmd[3:2] == 2'b11 && cmd != 4'b1111) |-> (ctl[0] == ctl[1] && ctl[0] != '0));
    // R2
    strobe_after_capture_chk: assert property (@(posedge clk)
        disable iff (!rst_n || !clear_n) (ctl != '0) |-> $past(frame_end));
endmodule

// File: rtl/dacif_channel.sv
// One channel: an input latch and a DAC latch. Load writes the input
// latch; update writes the DAC latch from the new data when loading in
// the same cycle, otherwise from the stored input latch.
// Assumes the data field is left-aligned; the low bits are dropped.
module dacif_channel
    import dacif_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_n,
    input  chan_ctl_t           ctl,
    input  logic [DATA_W-1:0]   data,
    output logic [RES_BITS-1:0] code
);
    logic [RES_BITS-1:0] in_q;
    logic [RES_BITS-1:0] dac_q;
    logic [RES_BITS-1:0] new_val;

    assign new_val = data[DATA_W-1 -: RES_BITS];

    // Purpose: double-buffered latch pair with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !clear_n) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            if (ctl.load) in_q <= new_val;
            if (ctl.upd)  dac_q <= ctl.load ? new_val : in_q;
        end
    end

    assign code = dac_q;

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        disable iff (!rst_n) !clear_n |=> (dac_q == '0 && in_q == '0));
    // R3
    load_only_hold_chk: assert property (@(posedge clk)
        disable iff (!rst_n || !clear_n) (ctl.load && !ctl.upd) |=> $stable(dac_q));
    // R4
    upd_from_input_chk: assert property (@(posedge clk)
        disable iff (!rst_n || !clear_n) (ctl.upd && !ctl.load) |=> (dac_q == $past(in_q)));
    // R5
    ldup_new_code_chk: assert property (@(posedge clk)
        disable iff (!rst_n || !clear_n) (ctl.upd && ctl.load) |=> (dac_q == in_q));
    // R7
    idle_latch_hold_chk: assert property (@(posedge clk)
        disable iff (!rst_n || !clear_n) (!ctl.load && !ctl.upd) |=> ($stable(dac_q) && $stable(in_q)));
endmodule

// File: rtl/dual_dac_serial_if.sv
// Top: serial receiver, command decoder and two latch channels.
// Assumes clk runs at least six times faster than sclk.
module dual_dac_serial_if
    import dacif_pkg::*;
#(
    parameter int RES_BITS    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_n,
    input  logic                sel_n,
    input  logic                sclk,
    input  logic                sdin,
    output logic                sdout,
    output logic [RES_BITS-1:0] code_a,
    output logic [RES_BITS-1:0] code_b
);
    logic               frame_end;
    logic [FRAME_W-1:0] shift_q;
    ctl_vec_t           ctl;
    logic [DATA_W-1:0]  data;
    logic [RES_BITS-1:0] codes [NCH];

    dacif_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .sel_n(sel_n),
        .sclk(sclk), .sdin(sdin), .sdout(sdout),
        .frame_end(frame_end), .shift_q(shift_q)
    );

    dacif_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .clear_n(clear_n),
        .frame_end(frame_end), .shift_q(shift_q),
        .ctl(ctl), .data(data)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        dacif_channel #(.RES_BITS(RES_BITS)) u_chan (
            .clk(clk), .rst_n(rst_n), .clear_n(clear_n),
            .ctl(ctl[ch]), .data(data), .code(codes[ch])
        );
    end

    assign code_a = codes[0];
    assign code_b = codes[1];
endmodule

// File: tb/dual_dac_serial_if_tb.sv
module dual_dac_serial_if_tb;
    localparam int PH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0, clear_n = 1'b1, sel_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic sdout, sdout8;
    logic [11:0] code_a, code_b;
    logic [7:0]  c8_a, c8_b;

    int checks = 0, failures = 0;
    logic [11:0] m_in_a = '0, m_in_b = '0, m_a = '0, m_b = '0;
    logic [15:0] prev_word = '0;

    typedef struct { logic [11:0] a; logic [11:0] b; string tag; } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;

    dual_dac_serial_if u_dut (
        .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .sel_n(sel_n),
        .sclk(sclk), .sdin(sdin), .sdout(sdout), .code_a(code_a), .code_b(code_b)
    );
    dual_dac_serial_if #(.RES_BITS(8)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .sel_n(sel_n),
        .sclk(sclk), .sdin(sdin), .sdout(sdout8), .code_a(c8_a), .code_b(c8_b)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Apply a word to the reference model (R3..R7).
    task automatic model(input logic [15:0] w);
        logic [11:0] d;
        logic la, ua, lb, ub;
        d = w[11:0];
        {la, ua, lb, ub} = 4'b0;
        case (w[15:12])
            4'b0000: la = 1;
            4'b0001: ua = 1;
            4'b0010: begin la = 1; ua = 1; end
            4'b0011: lb = 1;
            4'b0100: ub = 1;
            4'b0101: begin lb = 1; ub = 1; end
            4'b1100: begin la = 1; lb = 1; end
            4'b1101: begin ua = 1; ub = 1; end
            4'b1110: begin la = 1; ua = 1; lb = 1; ub = 1; end
            default: ;
        endcase
        if (ua) m_a = la ? d : m_in_a;
        if (ub) m_b = lb ? d : m_in_b;
        if (la) m_in_a = d;
        if (lb) m_in_b = d;
    endtask

    // Driver: send one frame, check the chained output, push the expectation.
    task automatic send(input logic [15:0] w, input string tag);
        logic [15:0] got;
        sel_n = 1'b0;
        wait_clk(PH);
        for (int i = 15; i >= 0; i--) begin
            sdin = w[i];
            wait_clk(PH);
            got[i] = sdout;
            sclk = 1'b1;
            wait_clk(PH);
            sclk = 1'b0;
        end
        wait_clk(PH);
        sel_n = 1'b1;
        // R9: previous word comes out MSB first
        check(got == prev_word, "R9 sdout", {16'h0, got}, {16'h0, prev_word});
        prev_word = w;
        wait_clk(12);
        model(w);
        sbq.push_back('{a: m_a, b: m_b, tag: tag});
        wait (sbq.size() == 0);
        wait_clk(1);
    endtask

    // Monitor: pop expectations and compare both instances (R10 on the 8-bit one).
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(code_a == e.a, {e.tag, " code_a"}, {20'h0, code_a}, {20'h0, e.a});
                check(code_b == e.b, {e.tag, " code_b"}, {20'h0, code_b}, {20'h0, e.b});
                check(c8_a == e.a[11:4] && c8_b == e.b[11:4], "R10 left-aligned",
                      {16'h0, c8_a, c8_b}, {16'h0, e.a[11:4], e.b[11:4]});
            end
        end
    end

    initial begin
        wait_clk(400000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1: reset state
        check(code_a == 0 && code_b == 0 && sdout == 0, "R1 reset", {8'h0, code_a, code_b}, 32'h0);

        send(16'h0ABC, "R3 load A");
        send(16'h1123, "R4 update A");
        send(16'h35A5, "R3 load B");
        send(16'h4000, "R4 update B");
        send(16'h2777, "R2 R5 ldup A");
        send(16'h50F0, "R5 ldup B");
        send(16'hC321, "R6 load all");
        send(16'hD000, "R6 update all");
        send(16'hEFED, "R6 ldup all");
        send(16'h0456, "R3 load A again");
        for (int c = 6; c <= 15; c++) begin
            if (c <= 11 || c == 15) send({c[3:0], 12'h999}, "R7 noop");
        end
        send(16'hD000, "R7 hidden latches intact");

        // R8: clocks while select is high must not shift
        sdin = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b1; wait_clk(PH);
            sclk = 1'b0; wait_clk(PH);
        end
        send(16'h6ACE, "R8 idle clocks ignored");

        // R1: clear overrides and zeroes everything, incl. shift register
        clear_n = 1'b0;
        wait_clk(3);
        clear_n = 1'b1;
        wait_clk(2);
        m_in_a = '0; m_in_b = '0; m_a = '0; m_b = '0; prev_word = '0;
        check(code_a == 0 && code_b == 0, "R1 clear", {8'h0, code_a, code_b}, 32'h0);
        send(16'h1FFF, "R1 cleared input latch");
        send(16'h2801, "R10 low bits dropped");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule